// File: doc/BRIEF.md
# Bidirectional Pad Cell with Input Capture

This block is one pin's worth of I/O logic. On the output side it picks one of a group of candidate logic outputs and presents it to the pad driver. A dedicated output-enable term gates that driver. On the input side it returns two things to the input routing at once: the live pad value and a stored copy of it. Because both are available together, logic downstream can compare a sample taken earlier with the value now on the pin. One typical use is checking time-multiplexed data arriving on the same wire.

The storage element is separate from any other register in the fabric, and it resets to 0. It works in one of two modes:

- an edge-triggered D register;
- a transparent D latch.

Either mode is clocked or enabled by one of four block clocks. The block clocks are level signals sampled in the system clock domain. An optional hold-fix setting delays the data into the storage element by one system clock. This matches a source whose data changes right after the clock edge.

The tri-state pad is modelled with separate drive-value, drive-enable and sensed-value signals. Resolution of the wire belongs to the surrounding pad model.

Top module: `pad_io_cell`

## Requirements
- R1: `pad_oe` equals `oe_term` in the same cycle. When it is 0 the pad is undriven, and the sensed pad value comes only from outside.
- R2: `pad_out` equals bit `mc_sel` of `mc_out` (index 0 to 7), combinationally.
- R3: `fb_direct` equals `pad_in` in the same cycle at all times, independent of mode and clocking.
- R4: With `cap_mode` = 0 (register), the stored value loads the capture data at the first system clock edge on which the block clock chosen by `clk_sel` (index 0 to 3) is 1 after having been 0. It holds at all other edges, including while the chosen clock stays high and while the other block clocks toggle.
- R5: With `cap_mode` = 1 (latch), `fb_stored` follows the capture data combinationally while the chosen block clock is 1. While that clock is 0, `fb_stored` keeps the capture data seen at the last system clock edge on which it was 1.
- R6: With `zht_en` = 0 the capture data is the current `pad_in`. With `zht_en` = 1 it is `pad_in` as sampled at the previous system clock edge.
- R7: Reset (`rst_n` = 0) clears the stored value to 0. Changes to `mc_out`, `mc_sel` or `oe_term` never alter the stored value except through the pad value captured at a clock event.
- R8: After a value is stored, a later different pad value appears on `fb_direct` while `fb_stored` still shows the earlier one. Their equality reflects whether the pad changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_out | input | 8 | Candidate logic outputs that may drive the pad |
| mc_sel | input | 3 | Index of the candidate that drives the pad |
| oe_term | input | 1 | Output-enable term for the pad driver |
| pad_out | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |
| pad_in | input | 1 | Value sensed on the pad |
| blk_clk | input | 4 | The four block clocks (levels) |
| clk_sel | input | 2 | Index of the block clock used by the storage element |
| cap_mode | input | 1 | 0 = edge register, 1 = transparent latch |
| zht_en | input | 1 | 1 = capture data delayed by one system clock |
| fb_direct | output | 1 | Live pad value to the input routing |
| fb_stored | output | 1 | Stored pad value to the input routing |

## Verification
The functions that collide are a capture event and a pad transition. They meet when the chosen block clock rises in the same cycle as a new value lands on the pad. The bench provokes this by driving both changes together, once with the hold-fix delay off and once with it on. It judges the result by the stored value: the new value is expected in the first case and the previous one in the second. A second collision puts output-path changes (enable, candidate select) next to a held capture, and the bench checks that the stored value does not move.

// File: rtl/pad_io_cell.sv
module pad_io_cell #(
  parameter int MUX_N = 8,
  parameter int NCLK  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MUX_N-1:0]         mc_out,
  input  logic [$clog2(MUX_N)-1:0] mc_sel,
  input  logic                     oe_term,
  output logic                     pad_out,
  output logic                     pad_oe,
  input  logic                     pad_in,
  input  logic [NCLK-1:0]          blk_clk,
  input  logic [$clog2(NCLK)-1:0]  clk_sel,
  input  logic                     cap_mode,
  input  logic                     zht_en,
  output logic                     fb_direct,
  output logic                     fb_stored
);

  logic en, en_q, rise, dly_q, cap_d, cap_q, load;

  assign pad_out   = mc_out[mc_sel];
  assign pad_oe    = oe_term;
  assign fb_direct = pad_in;

  assign en    = blk_clk[clk_sel];
  assign rise  = en & ~en_q;
  assign cap_d = zht_en ? dly_q : pad_in;
  assign load  = cap_mode ? en : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dly_q <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      en_q  <= en;
      dly_q <= pad_in;
      if (load) cap_q <= cap_d;
    end
  end

  assign fb_stored = (cap_mode && en) ? cap_d : cap_q;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !(en && !en_q)) |=> $stable(cap_q));

  p_reg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && en && !en_q && !zht_en) |=> cap_q == $past(pad_in));

  p_zht_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !cap_mode && en && !en_q && zht_en) |=> cap_q == $past(pad_in, 2));

  p_latch_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && !en) |=> (cap_q == $past(cap_q)));

endmodule

// File: tb/pad_io_cell_test.sv
module pad_io_cell_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] mc_out = '0;
  logic [2:0] mc_sel = '0;
  logic       oe_term = 0;
  logic       pad_out, pad_oe, pad_in;
  logic       ext = 0;
  logic [3:0] blk_clk = '0;
  logic [1:0] clk_sel = '0;
  logic       cap_mode = 0;
  logic       zht_en = 0;
  logic       fb_direct, fb_stored;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  assign pad_in = pad_oe ? pad_out : ext;

  pad_io_cell uut (
    .clk(clk), .rst_n(rst_n), .mc_out(mc_out), .mc_sel(mc_sel), .oe_term(oe_term),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .blk_clk(blk_clk),
    .clk_sel(clk_sel), .cap_mode(cap_mode), .zht_en(zht_en),
    .fb_direct(fb_direct), .fb_stored(fb_stored)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    blk_clk = '0;
    repeat (3) tick();
    check(fb_stored, 1'b0, "R7 stored clear in reset");
    rst_n = 1;
    tick();
    check(fb_stored, 1'b0, "R7 stored clear after reset");
  endtask

  task automatic t_output_path();
    mc_out  = 8'b1010_0110;
    oe_term = 1;
    for (int s = 0; s < 8; s++) begin
      mc_sel = 3'(s);
      #1;
      check(pad_out, mc_out[s], "R2 candidate select");
      check(fb_direct, mc_out[s], "R3 direct sees driven pad");
    end
    check(pad_oe, 1'b1, "R1 enable high");
    oe_term = 0;
    ext = 1;
    #1;
    check(pad_oe, 1'b0, "R1 enable low");
    check(fb_direct, 1'b1, "R3 direct sees external 1");
    ext = 0;
    #1;
    check(fb_direct, 1'b0, "R3 direct sees external 0");
    tick();
  endtask

  task automatic t_register();
    cap_mode = 0; zht_en = 0; clk_sel = 2; oe_term = 0;
    ext = 1; blk_clk[2] = 1;
    tick();
    check(fb_stored, 1'b1, "R4 load on rise");
    ext = 0;
    tick();
    check(fb_stored, 1'b1, "R4 hold while clock stays high");
    blk_clk[2] = 0;
    tick();
    check(fb_stored, 1'b1, "R4 hold on fall");
    blk_clk[0] = 1; blk_clk[3] = 1; blk_clk[1] = 1;
    tick();
    check(fb_stored, 1'b1, "R4 other clocks ignored");
    blk_clk = '0;
    tick();
    oe_term = 1; mc_sel = 0; mc_out = 8'h00;
    tick();
    mc_sel = 3; mc_out = 8'hFF;
    tick();
    check(fb_stored, 1'b1, "R7 output path does not disturb store");
    oe_term = 0;
    tick();
    blk_clk[2] = 1;
    tick();
    check(fb_stored, 1'b0, "R4 second rise loads 0");
    blk_clk[2] = 0;
    tick();
  endtask

  task automatic t_zht(input logic z, input logic exp, input string req);
    cap_mode = 0; zht_en = z; clk_sel = 1; oe_term = 0;
    blk_clk = '0; ext = exp;
    tick();
    tick();
    ext = ~exp; blk_clk[1] = 1;
    tick();
    check(fb_stored, z ? exp : ~exp, req);
    blk_clk = '0;
    tick();
  endtask

  task automatic t_latch();
    cap_mode = 1; zht_en = 0; clk_sel = 1; oe_term = 0;
    blk_clk = '0; ext = 0;
    tick();
    blk_clk[1] = 1; ext = 1;
    #1;
    check(fb_stored, 1'b1, "R5 transparent follows 1");
    ext = 0;
    #1;
    check(fb_stored, 1'b0, "R5 transparent follows 0");
    ext = 1;
    tick();
    blk_clk[1] = 0;
    #1;
    check(fb_stored, 1'b1, "R5 closed keeps last value");
    ext = 0;
    #1;
    check(fb_stored, 1'b1, "R5 closed ignores pad");
    tick();
    check(fb_stored, 1'b1, "R5 closed holds over edge");
    zht_en = 1; ext = 0;
    tick();
    blk_clk[1] = 1; ext = 1;
    #1;
    check(fb_stored, 1'b0, "R6 latch sees delayed data");
    tick();
    check(fb_stored, 1'b1, "R6 latch delayed data arrives");
    blk_clk = '0; zht_en = 0;
    tick();
  endtask

  task automatic t_compare();
    cap_mode = 0; zht_en = 0; clk_sel = 3; oe_term = 0;
    blk_clk = '0; ext = 1;
    tick();
    blk_clk[3] = 1;
    tick();
    blk_clk[3] = 0;
    tick();
    check(fb_stored, 1'b1, "R8 first value stored");
    check(fb_direct == fb_stored, 1'b1, "R8 equal when pad unchanged");
    ext = 0;
    #1;
    check(fb_direct, 1'b0, "R8 direct shows second value");
    check(fb_stored, 1'b1, "R8 stored keeps first value");
    check(fb_direct == fb_stored, 1'b0, "R8 mismatch flagged");
  endtask

  initial begin
    #(8 * 20000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_output_path();
    t_register();
    t_zht(1'b0, 1'b1, "R6 no delay takes new value");
    t_zht(1'b1, 1'b1, "R6 delay takes previous value");
    t_latch();
    t_compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule